// File: doc/BRIEF.md
# Sixteen-bit bus byte-lane controller

This block turns single byte and word transfer requests from inside the chip into cycles on a 16-bit external data bus. The bus has two byte lanes. The upper lane carries the byte at an even address. The lower lane carries the byte at an odd address. A low-byte strobe, together with bit 0 of the address, tells the outside world which lanes take part in the transfer. Write data is steered onto the correct lanes, and each lane has its own output enable. Read data is taken from the lanes and packed so that the byte from the lower address sits in the low byte of the result.

A requester presents one request with a single-cycle `req_valid` and waits for the one-cycle `req_done` before it sends the next. A word access at an odd address is legal only in emulation mode and only to internal RAM. It then swaps the bytes across the lanes. Any other odd word access is refused with an error and makes no bus cycle. The block refuses every request when the external bus is absent (single-chip operation). It stands still in stop mode. Between accesses every bus output keeps its last value, so no pins toggle needlessly.

Top module: `lanebus_ctrl`

## Requirements
- R1: An aligned word access (req_word=1, address bit 0 = 0) drives bus_lstrb=0 and bus_addr[0]=0. On a write, bus_dout_hi=req_wdata[7:0] and bus_dout_lo=req_wdata[15:8], with both lane enables high. On a read, req_rdata={bus_din_lo, bus_din_hi}.
- R2: A byte access at an odd address drives bus_lstrb=0 and bus_addr[0]=1, and uses only the lower lane. On a write, bus_dout_lo=req_wdata[7:0], bus_oe_lo=1 and bus_oe_hi=0.
- R3: A byte access at an even address drives bus_lstrb=1 and bus_addr[0]=0, and uses only the upper lane. On a write, bus_dout_hi=req_wdata[7:0], bus_oe_hi=1 and bus_oe_lo=0.
- R4: An odd-address word access with mode_emul=1 and req_iram=1 drives bus_lstrb=1 and bus_addr[0]=1. On a write, bus_dout_hi=req_wdata[15:8] and bus_dout_lo=req_wdata[7:0], with both enables high. On a read, req_rdata={bus_din_hi, bus_din_lo}.
- R5: An odd-address word access without both mode_emul=1 and req_iram=1 completes with req_done=1 and req_err=1 in the same cycle. It changes no bus output, and both lane enables stay low. req_err is never high without req_done.
- R6: A read drives bus_rw=1 with both lane enables low. A byte read returns the addressed lane in req_rdata[7:0] with req_rdata[15:8]=0, and ignores the other lane.
- R7: An accepted request shows its bus outputs in the cycle after the request edge. Lane enables stay high for exactly that one cycle. req_done rises one cycle later, and read data is valid with it. A refused request shows req_done one cycle after the request edge.
- R8: Between accesses, bus_addr, bus_lstrb, bus_rw and both data lanes keep their last values. A lane that an access does not drive keeps its previous data value.
- R9: While mode_stop=1, the block ignores requests, holds req_done low and leaves every bus output unchanged.
- R10: With mode_expanded=0 and mode_emul=0 (single-chip), every request is refused with req_done=1 and req_err=1, and no bus output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Single-cycle request strobe |
| req_addr | input | ADDR_W | Byte address of the request |
| req_word | input | 1 | 1 = word transfer, 0 = byte transfer |
| req_read | input | 1 | 1 = read, 0 = write |
| req_wdata | input | 2*LANE_W | Write data; low byte belongs to the lower address |
| req_iram | input | 1 | Target is internal RAM |
| mode_emul | input | 1 | Emulation mode (external bus present) |
| mode_expanded | input | 1 | Expanded mode (external bus present) |
| mode_stop | input | 1 | Stop mode: block frozen |
| req_done | output | 1 | One-cycle completion pulse |
| req_err | output | 1 | Request refused; valid with req_done |
| req_rdata | output | 2*LANE_W | Packed read data; low byte from the lower address |
| bus_addr | output | ADDR_W | External address, held between accesses |
| bus_lstrb | output | 1 | Low-byte strobe |
| bus_rw | output | 1 | 1 = read, 0 = write |
| bus_dout_hi | output | LANE_W | Upper-lane write data |
| bus_dout_lo | output | LANE_W | Lower-lane write data |
| bus_oe_hi | output | 1 | Upper-lane output enable |
| bus_oe_lo | output | 1 | Lower-lane output enable |
| bus_din_hi | input | LANE_W | Upper-lane read data |
| bus_din_lo | input | LANE_W | Lower-lane read data |

## Verification
The properties assume that the mode inputs change only while no transfer is in flight. The single-chip check reads the modes in the cycle of `req_done`, and the refusal check reads the bus one cycle after the request. The properties also assume that a new request never arrives before the previous `req_done`, so a lane enable never follows on from a second write. The bench changes modes only on idle cycles and waits for each completion before its next request. It holds the read lanes steady from before the request edge until the capture edge.

// File: rtl/lanebus_pkg.sv
// Shared types for the 16-bit byte-lane bus controller.
// Assumes two byte lanes; the upper lane carries even-address bytes.
package lanebus_pkg;

    // Access class chosen from size, address bit 0 and mode.
    typedef enum logic [2:0] {
        KIND_WORD_EVEN = 3'd0,
        KIND_BYTE_ODD  = 3'd1,
        KIND_BYTE_EVEN = 3'd2,
        KIND_WORD_SWAP = 3'd3,
        KIND_REJECT    = 3'd4
    } lane_kind_e;

    // Lane plan for one access.
    typedef struct packed {
        lane_kind_e kind;
        logic       strobe;
        logic       use_hi;
        logic       use_lo;
        logic       swap;
    } lane_plan_t;

    // Sequencer states.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_XFER = 1'b1
    } seq_state_e;

endpackage

// File: rtl/lanebus_decode.sv
// Classifies a request into a lane plan.
// Purely combinational; assumes the inputs are stable while req_valid is high.
module lanebus_decode
    import lanebus_pkg::*;
(
    input  logic       addr0,
    input  logic       is_word,
    input  logic       to_iram,
    input  logic       emul,
    input  logic       bus_on,
    output lane_plan_t plan
);

    lane_kind_e kind;

    // Pick the access class.
    always_comb begin
        if (!bus_on) begin
            kind = KIND_REJECT;
        end else if (is_word && !addr0) begin
            kind = KIND_WORD_EVEN;
        end else if (is_word) begin
            kind = (emul && to_iram) ? KIND_WORD_SWAP : KIND_REJECT;
        end else if (addr0) begin
            kind = KIND_BYTE_ODD;
        end else begin
            kind = KIND_BYTE_EVEN;
        end
    end

    // Derive the strobe code and the lane usage from the class.
    always_comb begin
        plan.kind   = kind;
        plan.strobe = 1'b0;
        plan.use_hi = 1'b0;
        plan.use_lo = 1'b0;
        plan.swap   = 1'b0;
        case (kind)
            KIND_WORD_EVEN: begin
                plan.use_hi = 1'b1;
                plan.use_lo = 1'b1;
            end
            KIND_BYTE_ODD: begin
                plan.use_lo = 1'b1;
            end
            KIND_BYTE_EVEN: begin
                plan.strobe = 1'b1;
                plan.use_hi = 1'b1;
            end
            KIND_WORD_SWAP: begin
                plan.strobe = 1'b1;
                plan.use_hi = 1'b1;
                plan.use_lo = 1'b1;
                plan.swap   = 1'b1;
            end
            default: begin
                plan.strobe = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/lanebus_drive.sv
// Holds the external bus outputs and steers write bytes onto the lanes.
// Outputs change only on load. Lane enables last one cycle after a write load.
// hold freezes every register (stop mode).
module lanebus_drive
    import lanebus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LANE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  hold,
    input  logic                  load,
    input  lane_plan_t            plan,
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  is_read,
    input  logic [2*LANE_W-1:0]   wdata,
    output logic [ADDR_W-1:0]     bus_addr,
    output logic                  bus_lstrb,
    output logic                  bus_rw,
    output logic [LANE_W-1:0]     bus_dout_hi,
    output logic [LANE_W-1:0]     bus_dout_lo,
    output logic                  bus_oe_hi,
    output logic                  bus_oe_lo
);

    localparam int NLANE = 2;

    logic [LANE_W-1:0] byte_lo;
    logic [LANE_W-1:0] byte_up;
    logic [LANE_W-1:0] lane_src [NLANE];
    logic              lane_use [NLANE];

    assign byte_lo = wdata[LANE_W-1:0];
    assign byte_up = wdata[2*LANE_W-1:LANE_W];

    // Lane 1 is the upper (even) lane, lane 0 the lower (odd) lane.
    assign lane_src[1] = plan.swap ? byte_up : byte_lo;
    assign lane_src[0] = (plan.kind == KIND_WORD_EVEN) ? byte_up : byte_lo;
    assign lane_use[1] = plan.use_hi;
    assign lane_use[0] = plan.use_lo;

    // Address, strobe and direction: updated on load, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_addr  <= '0;
            bus_lstrb <= 1'b1;
            bus_rw    <= 1'b1;
        end else if (!hold && load) begin
            bus_addr  <= addr;
            bus_lstrb <= plan.strobe;
            bus_rw    <= is_read;
        end
    end

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        logic [LANE_W-1:0] q;
        logic              oe;
        // Per-lane data latch and single-cycle output enable.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q  <= '0;
                oe <= 1'b0;
            end else if (!hold) begin
                oe <= load && !is_read && lane_use[g];
                if (load && !is_read && lane_use[g]) begin
                    q <= lane_src[g];
                end
            end
        end
    end

    assign bus_dout_hi = g_lane[1].q;
    assign bus_dout_lo = g_lane[0].q;
    assign bus_oe_hi   = g_lane[1].oe;
    assign bus_oe_lo   = g_lane[0].oe;

endmodule

// File: rtl/lanebus_rdpack.sv
// Captures the two read lanes and packs them so the lower address byte is low.
// Byte reads zero the upper result byte. The result holds until the next capture.
module lanebus_rdpack
    import lanebus_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  capture,
    input  lane_kind_e            kind,
    input  logic [LANE_W-1:0]     din_hi,
    input  logic [LANE_W-1:0]     din_lo,
    output logic [2*LANE_W-1:0]   rdata
);

    logic [2*LANE_W-1:0] packed_nxt;

    // Reorder the lanes according to the access class.
    always_comb begin
        case (kind)
            KIND_WORD_EVEN: packed_nxt = {din_lo, din_hi};
            KIND_BYTE_ODD:  packed_nxt = {{LANE_W{1'b0}}, din_lo};
            KIND_BYTE_EVEN: packed_nxt = {{LANE_W{1'b0}}, din_hi};
            KIND_WORD_SWAP: packed_nxt = {din_hi, din_lo};
            default:        packed_nxt = '0;
        endcase
    end

    // Register the packed result on capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (capture) begin
            rdata <= packed_nxt;
        end
    end

endmodule

// File: rtl/lanebus_ctrl.sv
// Top of the byte-lane bus controller: sequences one transfer per request.
// Assumes the requester waits for req_done before the next req_valid.
// A request edge loads the bus; the next edge captures read data and raises done.
module lanebus_ctrl
    import lanebus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LANE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic                  req_word,
    input  logic                  req_read,
    input  logic [2*LANE_W-1:0]   req_wdata,
    input  logic                  req_iram,
    input  logic                  mode_emul,
    input  logic                  mode_expanded,
    input  logic                  mode_stop,
    output logic                  req_done,
    output logic                  req_err,
    output logic [2*LANE_W-1:0]   req_rdata,
    output logic [ADDR_W-1:0]     bus_addr,
    output logic                  bus_lstrb,
    output logic                  bus_rw,
    output logic [LANE_W-1:0]     bus_dout_hi,
    output logic [LANE_W-1:0]     bus_dout_lo,
    output logic                  bus_oe_hi,
    output logic                  bus_oe_lo,
    input  logic [LANE_W-1:0]     bus_din_hi,
    input  logic [LANE_W-1:0]     bus_din_lo
);

    lane_plan_t plan;
    seq_state_e state;
    lane_kind_e cur_kind;
    logic       cur_read;
    logic       accept;
    logic       refuse;
    logic       load;
    logic       capture;

    lanebus_decode u_decode (
        .addr0   (req_addr[0]),
        .is_word (req_word),
        .to_iram (req_iram),
        .emul    (mode_emul),
        .bus_on  (mode_expanded | mode_emul),
        .plan    (plan)
    );

    assign accept  = req_valid && (state == ST_IDLE) && !mode_stop;
    assign refuse  = accept && (plan.kind == KIND_REJECT);
    assign load    = accept && (plan.kind != KIND_REJECT);
    assign capture = (state == ST_XFER) && cur_read && !mode_stop;

    // Sequencer: idle -> transfer -> idle, with done and error pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cur_kind <= KIND_WORD_EVEN;
            cur_read <= 1'b0;
            req_done <= 1'b0;
            req_err  <= 1'b0;
        end else if (mode_stop) begin
            req_done <= 1'b0;
            req_err  <= 1'b0;
        end else begin
            req_done <= refuse || (state == ST_XFER);
            req_err  <= refuse;
            if (load) begin
                state    <= ST_XFER;
                cur_kind <= plan.kind;
                cur_read <= req_read;
            end else if (state == ST_XFER) begin
                state <= ST_IDLE;
            end
        end
    end

    lanebus_drive #(
        .ADDR_W (ADDR_W),
        .LANE_W (LANE_W)
    ) u_drive (
        .clk         (clk),
        .rst_n       (rst_n),
        .hold        (mode_stop),
        .load        (load),
        .plan        (plan),
        .addr        (req_addr),
        .is_read     (req_read),
        .wdata       (req_wdata),
        .bus_addr    (bus_addr),
        .bus_lstrb   (bus_lstrb),
        .bus_rw      (bus_rw),
        .bus_dout_hi (bus_dout_hi),
        .bus_dout_lo (bus_dout_lo),
        .bus_oe_hi   (bus_oe_hi),
        .bus_oe_lo   (bus_oe_lo)
    );

    lanebus_rdpack #(
        .LANE_W (LANE_W)
    ) u_rdpack (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .kind    (cur_kind),
        .din_hi  (bus_din_hi),
        .din_lo  (bus_din_lo),
        .rdata   (req_rdata)
    );

endmodule

// File: rtl/lanebus_chk.sv
// Assertion checker for lanebus_ctrl, attached by bind.
// Assumes modes change only while no transfer is in flight.
module lanebus_chk #(
    parameter int ADDR_W = 16,
    parameter int LANE_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                mode_emul,
    input logic                mode_expanded,
    input logic                mode_stop,
    input logic                req_done,
    input logic                req_err,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_lstrb,
    input logic                bus_rw,
    input logic [LANE_W-1:0]   bus_dout_hi,
    input logic                bus_oe_hi,
    input logic                bus_oe_lo
);

    AST_WORD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe_hi && bus_oe_lo) |-> (bus_lstrb == bus_addr[0])); // R1
    AST_LO_LANE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe_lo && !bus_oe_hi) |-> (!bus_lstrb && bus_addr[0])); // R2
    AST_HI_LANE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe_hi && !bus_oe_lo) |-> (bus_lstrb && !bus_addr[0])); // R3
    AST_SWAP_NEEDS_EMUL: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe_hi && bus_oe_lo && bus_addr[0]) |-> mode_emul); // R4
    AST_REFUSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (req_done && req_err) |-> ($stable(bus_addr) && $stable(bus_rw)
                                   && !bus_oe_hi && !bus_oe_lo)); // R5
    AST_ERR_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> req_done); // R5
    AST_READ_NO_OE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rw |-> (!bus_oe_hi && !bus_oe_lo)); // R6
    AST_OE_HI_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe_hi && !mode_stop) |=> !bus_oe_hi); // R7
    AST_OE_LO_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe_lo && !mode_stop) |=> !bus_oe_lo); // R7
    AST_STOP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        mode_stop |=> (!req_done && $stable(bus_addr) && $stable(bus_dout_hi))); // R9
    AST_SINGLE_CHIP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_done && !mode_expanded && !mode_emul) |-> req_err); // R10

endmodule

bind lanebus_ctrl lanebus_chk #(
    .ADDR_W (ADDR_W),
    .LANE_W (LANE_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_emul     (mode_emul),
    .mode_expanded (mode_expanded),
    .mode_stop     (mode_stop),
    .req_done      (req_done),
    .req_err       (req_err),
    .bus_addr      (bus_addr),
    .bus_lstrb     (bus_lstrb),
    .bus_rw        (bus_rw),
    .bus_dout_hi   (bus_dout_hi),
    .bus_oe_hi     (bus_oe_hi),
    .bus_oe_lo     (bus_oe_lo)
);

// File: tb/sim_lanebus_ctrl.sv
// Directed bench for lanebus_ctrl: one task per scenario.
module sim_lanebus_ctrl;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic        req_word = 1'b0;
    logic        req_read = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        req_iram = 1'b0;
    logic        mode_emul = 1'b0;
    logic        mode_expanded = 1'b1;
    logic        mode_stop = 1'b0;
    logic        req_done;
    logic        req_err;
    logic [15:0] req_rdata;
    logic [15:0] bus_addr;
    logic        bus_lstrb;
    logic        bus_rw;
    logic [7:0]  bus_dout_hi;
    logic [7:0]  bus_dout_lo;
    logic        bus_oe_hi;
    logic        bus_oe_lo;
    logic [7:0]  bus_din_hi = '0;
    logic [7:0]  bus_din_lo = '0;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lanebus_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_word(req_word), .req_read(req_read), .req_wdata(req_wdata),
        .req_iram(req_iram), .mode_emul(mode_emul), .mode_expanded(mode_expanded),
        .mode_stop(mode_stop), .req_done(req_done), .req_err(req_err),
        .req_rdata(req_rdata), .bus_addr(bus_addr), .bus_lstrb(bus_lstrb),
        .bus_rw(bus_rw), .bus_dout_hi(bus_dout_hi), .bus_dout_lo(bus_dout_lo),
        .bus_oe_hi(bus_oe_hi), .bus_oe_lo(bus_oe_lo),
        .bus_din_hi(bus_din_hi), .bus_din_lo(bus_din_lo)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Present one request at a falling edge; return at the falling edge after it is taken.
    task automatic issue(input logic [15:0] a, input logic w, input logic r,
                         input logic [15:0] wd, input logic ir);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_word = w; req_read = r;
        req_wdata = wd; req_iram = ir;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R7 reset done", req_done, 0);
        chk("R5 reset err", req_err, 0);
        chk("R7 reset oe", {bus_oe_hi, bus_oe_lo}, 2'b00);
        chk("R6 reset rw", bus_rw, 1);
        chk("R6 reset rdata", req_rdata, 0);
    endtask

    task automatic t_word_write();
        issue(16'h1230, 1, 0, 16'hBEEF, 0);
        chk("R1 addr", bus_addr, 16'h1230);
        chk("R1 strobe", bus_lstrb, 0);
        chk("R1 rw", bus_rw, 0);
        chk("R1 hi lane", bus_dout_hi, 8'hEF);
        chk("R1 lo lane", bus_dout_lo, 8'hBE);
        chk("R1 oe", {bus_oe_hi, bus_oe_lo}, 2'b11);
        chk("R7 no early done", req_done, 0);
        step();
        chk("R7 done", {req_done, req_err}, 2'b10);
        chk("R7 oe off", {bus_oe_hi, bus_oe_lo}, 2'b00);
        chk("R8 data held", bus_dout_hi, 8'hEF);
        step();
        chk("R7 done single", req_done, 0);
    endtask

    task automatic t_odd_byte_write();
        issue(16'h2001, 0, 0, 16'h9955, 0);
        chk("R2 addr", bus_addr, 16'h2001);
        chk("R2 strobe", bus_lstrb, 0);
        chk("R2 lo lane", bus_dout_lo, 8'h55);
        chk("R2 oe", {bus_oe_hi, bus_oe_lo}, 2'b01);
        chk("R8 idle lane held", bus_dout_hi, 8'hEF);
        step();
        chk("R2 done", {req_done, req_err}, 2'b10);
    endtask

    task automatic t_even_byte_write();
        issue(16'h3002, 0, 0, 16'h66A7, 0);
        chk("R3 addr", bus_addr, 16'h3002);
        chk("R3 strobe", bus_lstrb, 1);
        chk("R3 hi lane", bus_dout_hi, 8'hA7);
        chk("R3 oe", {bus_oe_hi, bus_oe_lo}, 2'b10);
        chk("R8 idle lane held", bus_dout_lo, 8'h55);
        step();
        chk("R3 done", {req_done, req_err}, 2'b10);
    endtask

    task automatic t_swap_write();
        mode_emul = 1'b1;
        issue(16'h4005, 1, 0, 16'h1357, 1);
        chk("R4 addr", bus_addr, 16'h4005);
        chk("R4 strobe", bus_lstrb, 1);
        chk("R4 hi lane", bus_dout_hi, 8'h13);
        chk("R4 lo lane", bus_dout_lo, 8'h57);
        chk("R4 oe", {bus_oe_hi, bus_oe_lo}, 2'b11);
        step();
        chk("R4 done", {req_done, req_err}, 2'b10);
        mode_emul = 1'b0;
    endtask

    task automatic t_word_read();
        bus_din_hi = 8'h3C; bus_din_lo = 8'h96;
        issue(16'h5000, 1, 1, 16'hFFFF, 0);
        chk("R6 rw", bus_rw, 1);
        chk("R6 oe off", {bus_oe_hi, bus_oe_lo}, 2'b00);
        chk("R1 read strobe", bus_lstrb, 0);
        chk("R8 lane held on read", bus_dout_lo, 8'h57);
        step();
        chk("R1 read done", req_done, 1);
        chk("R1 read data", req_rdata, 16'h963C);
    endtask

    task automatic t_byte_reads();
        bus_din_hi = 8'hAA; bus_din_lo = 8'h11;
        issue(16'h5001, 0, 1, 16'h0000, 0);
        chk("R2 read strobe", {bus_lstrb, bus_addr[0]}, 2'b01);
        step();
        chk("R6 odd byte read", req_rdata, 16'h0011);
        issue(16'h5002, 0, 1, 16'h0000, 0);
        chk("R3 read strobe", {bus_lstrb, bus_addr[0]}, 2'b10);
        step();
        chk("R6 even byte read", req_rdata, 16'h00AA);
    endtask

    task automatic t_swap_read();
        mode_emul = 1'b1;
        bus_din_hi = 8'hC4; bus_din_lo = 8'h7E;
        issue(16'h6007, 1, 1, 16'h0000, 1);
        chk("R4 read strobe", {bus_lstrb, bus_addr[0]}, 2'b11);
        step();
        chk("R4 read data", req_rdata, 16'hC47E);
        mode_emul = 1'b0;
    endtask

    task automatic t_refuse();
        issue(16'h7003, 1, 0, 16'hFFFF, 1);
        chk("R5 done err", {req_done, req_err}, 2'b11);
        chk("R5 addr kept", bus_addr, 16'h6007);
        chk("R5 rw kept", bus_rw, 1);
        chk("R5 oe off", {bus_oe_hi, bus_oe_lo}, 2'b00);
        step();
        chk("R5 single done", req_done, 0);
        mode_emul = 1'b1;
        issue(16'h7003, 1, 0, 16'hFFFF, 0);
        chk("R5 not iram", {req_done, req_err}, 2'b11);
        chk("R5 lanes kept", {bus_dout_hi, bus_dout_lo}, 16'h1357);
        step();
        mode_emul = 1'b0;
    endtask

    task automatic t_single_chip();
        mode_expanded = 1'b0;
        issue(16'h8000, 1, 0, 16'h1234, 0);
        chk("R10 refused", {req_done, req_err}, 2'b11);
        chk("R10 addr kept", bus_addr, 16'h6007);
        chk("R10 oe off", {bus_oe_hi, bus_oe_lo}, 2'b00);
        step();
        mode_expanded = 1'b1;
    endtask

    task automatic t_stop();
        mode_stop = 1'b1;
        issue(16'h9000, 1, 0, 16'h4242, 0);
        chk("R9 no done", req_done, 0);
        chk("R9 addr kept", bus_addr, 16'h6007);
        chk("R9 oe off", {bus_oe_hi, bus_oe_lo}, 2'b00);
        step();
        chk("R9 still no done", req_done, 0);
        mode_stop = 1'b0;
        issue(16'h9000, 0, 0, 16'h0042, 0);
        chk("R9 resumes", {bus_addr, bus_dout_hi, bus_oe_hi}, {16'h9000, 8'h42, 1'b1});
        step();
        chk("R9 resumed done", req_done, 1);
    endtask

    task automatic t_hold();
        repeat (3) step();
        chk("R8 addr held", bus_addr, 16'h9000);
        chk("R8 strobe rw held", {bus_lstrb, bus_rw}, 2'b10);
        chk("R8 data held", {bus_dout_hi, bus_dout_lo}, 16'h4257);
        chk("R8 no oe", {bus_oe_hi, bus_oe_lo}, 2'b00);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_word_write();
        t_odd_byte_write();
        t_even_byte_write();
        t_swap_write();
        t_word_read();
        t_byte_reads();
        t_swap_read();
        t_refuse();
        t_single_chip();
        t_stop();
        t_hold();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule